// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block runs the auto-increment word programming mode of a serial flash. A byte deserialiser in front of it supplies whole command bytes, framed by a select-active signal. The sequencer turns those bytes into pairs of byte-write requests for the memory array. The first auto-increment command of a session carries a 24-bit start address and two data bytes. Every later command carries only the opcode and two data bytes, and it programs the next word in sequence.

A command takes effect only when its frame closes, and only if the frame held exactly the right number of bytes. The block owns the write-enable latch, which must be set before a session can start. Each programmed word is followed by a busy window of fixed length, which stands in for the array write time. While that window lasts, the block can show ready/busy on the serial output line.

The session ends in one of two ways: on a write-disable or read-status command given while ready, or when the top word of the array has been programmed. The address never wraps. The states are ST_IDLE, ST_WR_LO, ST_WR_HI, ST_BUSY and ST_READY. The transitions are:
- first-command: ST_IDLE to ST_WR_LO
- low-done: ST_WR_LO to ST_WR_HI
- high-done: ST_WR_HI to ST_BUSY
- room-left: ST_BUSY to ST_READY
- top-reached: ST_BUSY to ST_IDLE
- next-command: ST_READY to ST_WR_LO
- exit-command: ST_READY to ST_IDLE

Top module: `aai_seq`

## Requirements
- R1: After reset, aai_mode, wel, busy, wr_req and so_oe are all 0.
- R2: Outside the busy window, a one-byte frame 06h sets wel and a one-byte frame 04h clears it.
- R3: A six-byte frame (ADh, three address bytes MSB first, D0, D1) received in ST_IDLE with wel=1 writes D0 at {A[ADDR_W-1:1],0} and then D1 at {A[ADDR_W-1:1],1}, on two consecutive cycles, and sets aai_mode. If wel=0, the frame is ignored. While aai_mode=1, wel stays 1.
- R4: In ST_READY, a three-byte frame (ADh, D0, D1) writes D0 and D1 at the two bytes of the word that follows the previous one.
- R5: An ADh frame of any other length, or of the wrong kind for the current mode, produces no write and leaves aai_mode unchanged.
- R6: busy is high for exactly BUSY_CYC+2 consecutive cycles, starting with the low-byte write. Any command received in that window, other than 70h or 80h, has no effect.
- R7: After a one-byte 70h, so_oe=1 whenever aai_mode=1 and the frame is inactive, and so_val=~busy. After a one-byte 80h, so_oe=0.
- R8: In ST_READY, a 04h frame (one byte) or a 05h frame (one or more bytes) clears both aai_mode and wel. Either command received during the busy window is ignored.
- R9: When the word at the all-ones word address has been programmed, aai_mode and wel clear once the busy window ends, and later continuation frames produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame | input | 1 | High while the device is selected |
| byte_vld | input | 1 | One-cycle strobe for a received byte |
| byte_dat | input | 8 | Received byte |
| wr_req | output | 1 | Array byte-write request |
| wr_addr | output | ADDR_W | Byte address of the write |
| wr_dat | output | 8 | Byte to write |
| aai_mode | output | 1 | Auto-increment session active |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Word write in progress |
| so_oe | output | 1 | Serial output drives the status |
| so_val | output | 1 | Status value (1 = ready) |

## Verification
A corrupted word address or a byte-select error shows on wr_addr in the same cycle as the write request. The bench logs every request, so such an error is caught within the first word of the session. A busy count that is wrong shows as a busy window of the wrong length, or as a continuation frame that is accepted when it should be dropped. Either is visible at the end of the affected word. A state machine that stays in the session too long, or leaves it too early, shows at the next frame, through aai_mode, wel, or a write that appears or goes missing.

// File: rtl/aai_pkg.sv
package aai_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_LO,
        ST_WR_HI,
        ST_BUSY,
        ST_READY
    } aai_state_t;

    localparam logic [7:0] OPC_WREN    = 8'h06;
    localparam logic [7:0] OPC_WRDI    = 8'h04;
    localparam logic [7:0] OPC_RDSR    = 8'h05;
    localparam logic [7:0] OPC_AAI     = 8'hAD;
    localparam logic [7:0] OPC_BSY_ON  = 8'h70;
    localparam logic [7:0] OPC_BSY_OFF = 8'h80;

    localparam logic [2:0] LEN_FIRST = 3'd6;
    localparam logic [2:0] LEN_NEXT  = 3'd3;
    localparam logic [2:0] LEN_ONE   = 3'd1;
endpackage

// File: rtl/aai_frame_rx.sv
module aai_frame_rx #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame,
    input  logic              byte_vld,
    input  logic [7:0]        byte_dat,
    output logic              cmd_stb,
    output logic [7:0]        cmd_op,
    output logic [2:0]        cmd_len,
    output logic [ADDR_W-2:0] cmd_waddr,
    output logic [7:0]        cmd_d0,
    output logic [7:0]        cmd_d1
);
    localparam int WA_W = ADDR_W - 1;

    logic        frame_q;
    logic [2:0]  cnt_q;
    logic [2:0]  cnt_eff;
    logic [7:0]  op_q;
    logic [23:0] addr_q;
    logic [7:0]  d0_q;
    logic [7:0]  d1_q;

    assign cnt_eff = (frame && !frame_q) ? 3'd0 : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= 1'b0;
            cmd_stb <= 1'b0;
            cnt_q   <= '0;
            op_q    <= '0;
            addr_q  <= '0;
            d0_q    <= '0;
            d1_q    <= '0;
        end else begin
            frame_q <= frame;
            cmd_stb <= frame_q && !frame;
            if (frame && !frame_q)
                cnt_q <= '0;
            if (frame && byte_vld) begin
                if (cnt_eff != 3'd7)
                    cnt_q <= cnt_eff + 3'd1;
                if (cnt_eff == 3'd0)
                    op_q <= byte_dat;
                if (cnt_eff >= 3'd1 && cnt_eff <= 3'd3)
                    addr_q <= {addr_q[15:0], byte_dat};
                d0_q <= d1_q;
                d1_q <= byte_dat;
            end
        end
    end

    assign cmd_op    = op_q;
    assign cmd_len   = cnt_q;
    assign cmd_waddr = WA_W'(addr_q >> 1);
    assign cmd_d0    = d0_q;
    assign cmd_d1    = d1_q;

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb); // R5
endmodule

// File: rtl/aai_busy_tmr.sv
module aai_busy_tmr #(
    parameter int BUSY_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic last
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNT_W'(BUSY_CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CNT_W'(1));

    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == CNT_W'(BUSY_CYC))); // R6
endmodule

// File: rtl/aai_seq.sv
module aai_seq
    import aai_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int BUSY_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame,
    input  logic              byte_vld,
    input  logic [7:0]        byte_dat,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_dat,
    output logic              aai_mode,
    output logic              wel,
    output logic              busy,
    output logic              so_oe,
    output logic              so_val
);
    localparam int WA_W = ADDR_W - 1;

    logic            cmd_stb;
    logic [7:0]      cmd_op;
    logic [2:0]      cmd_len;
    logic [WA_W-1:0] cmd_waddr;
    logic [7:0]      cmd_d0;
    logic [7:0]      cmd_d1;
    logic            tmr_last;

    aai_state_t      state, state_nx;
    logic [WA_W-1:0] waddr_q;
    logic [7:0]      lo_q, hi_q;
    logic            wel_q, bsy_en_q;

    logic hit_first, hit_next, hit_exit, hit_wren, hit_wrdi, open_st, word_top;

    aai_frame_rx #(.ADDR_W(ADDR_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .frame(frame), .byte_vld(byte_vld),
        .byte_dat(byte_dat), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
        .cmd_len(cmd_len), .cmd_waddr(cmd_waddr), .cmd_d0(cmd_d0),
        .cmd_d1(cmd_d1)
    );

    aai_busy_tmr #(.BUSY_CYC(BUSY_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(state == ST_WR_HI), .last(tmr_last)
    );

    assign open_st   = (state == ST_IDLE) || (state == ST_READY);
    assign hit_first = cmd_stb && cmd_op == OPC_AAI && cmd_len == LEN_FIRST && wel_q;
    assign hit_next  = cmd_stb && cmd_op == OPC_AAI && cmd_len == LEN_NEXT;
    assign hit_wrdi  = cmd_stb && cmd_op == OPC_WRDI && cmd_len == LEN_ONE;
    assign hit_wren  = cmd_stb && cmd_op == OPC_WREN && cmd_len == LEN_ONE;
    assign hit_exit  = hit_wrdi || (cmd_stb && cmd_op == OPC_RDSR && cmd_len != 3'd0);
    assign word_top  = &waddr_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (hit_first) state_nx = ST_WR_LO;
            ST_WR_LO: state_nx = ST_WR_HI;
            ST_WR_HI: state_nx = ST_BUSY;
            ST_BUSY:  if (tmr_last) state_nx = word_top ? ST_IDLE : ST_READY;
            ST_READY: begin
                if (hit_next)      state_nx = ST_WR_LO;
                else if (hit_exit) state_nx = ST_IDLE;
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            waddr_q  <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
            wel_q    <= 1'b0;
            bsy_en_q <= 1'b0;
        end else begin
            state <= state_nx;
            if ((state == ST_IDLE && hit_first) || (state == ST_READY && hit_next)) begin
                lo_q <= cmd_d0;
                hi_q <= cmd_d1;
            end
            if (state == ST_IDLE && hit_first)
                waddr_q <= cmd_waddr;
            if (state == ST_BUSY && tmr_last && !word_top)
                waddr_q <= waddr_q + 1'b1;
            if (cmd_stb && cmd_len == LEN_ONE && cmd_op == OPC_BSY_ON)
                bsy_en_q <= 1'b1;
            else if (cmd_stb && cmd_len == LEN_ONE && cmd_op == OPC_BSY_OFF)
                bsy_en_q <= 1'b0;
            if (state != ST_IDLE && state_nx == ST_IDLE)
                wel_q <= 1'b0;
            else if (open_st && hit_wren)
                wel_q <= 1'b1;
            else if (open_st && hit_wrdi)
                wel_q <= 1'b0;
        end
    end

    always_comb begin
        wr_req   = (state == ST_WR_LO) || (state == ST_WR_HI);
        wr_addr  = {waddr_q, state == ST_WR_HI};
        wr_dat   = (state == ST_WR_HI) ? hi_q : lo_q;
        busy     = wr_req || (state == ST_BUSY);
        aai_mode = (state != ST_IDLE);
        wel      = wel_q;
        so_oe    = bsy_en_q && aai_mode && !frame;
        so_val   = !busy;
    end

    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_addr[0]) |=> (wr_req && wr_addr[0] &&
        wr_addr[ADDR_W-1:1] == $past(wr_addr[ADDR_W-1:1]))); // R3
    AST_ENTRY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aai_mode) |-> $past(wel)); // R3
    AST_MODE_HOLDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        aai_mode |-> wel); // R3
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !tmr_last) |=> (state == ST_BUSY)); // R6
    AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aai_mode) |-> !wel); // R8
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && $past(state) == ST_BUSY) |-> (waddr_q != '0)); // R9
endmodule

// File: tb/test_aai_seq.sv
module test_aai_seq;
    localparam int AW = 8;
    localparam int BC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame = 1'b0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_dat = '0;
    logic          wr_req, aai_mode, wel, busy, so_oe, so_val;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_dat;

    aai_seq #(.ADDR_W(AW), .BUSY_CYC(BC)) i_aai_seq (
        .clk(clk), .rst_n(rst_n), .frame(frame), .byte_vld(byte_vld),
        .byte_dat(byte_dat), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_dat(wr_dat), .aai_mode(aai_mode), .wel(wel), .busy(busy),
        .so_oe(so_oe), .so_val(so_val)
    );

    always #2 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    logic [7:0] tx[8];
    logic [7:0] log_a[16];
    logic [7:0] log_d[16];
    int nlog = 0;
    int brun = 0;
    int blast = 0;

    always @(negedge clk) begin
        if (rst_n && wr_req && nlog < 16) begin
            log_a[nlog] = wr_addr;
            log_d[nlog] = wr_dat;
            nlog++;
        end
        if (busy) brun++;
        else if (brun != 0) begin blast = brun; brun = 0; end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input int n);
        @(negedge clk); frame = 1'b1;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            byte_dat = tx[i]; byte_vld = 1'b1;
            @(negedge clk); byte_vld = 1'b0;
            @(negedge clk);
        end
        frame = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic settle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic op1(input logic [7:0] b);
        tx[0] = b; send(1); settle();
    endtask

    task automatic first(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1);
        tx[0] = 8'hAD; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = a; tx[4] = d0; tx[5] = d1;
        send(6);
    endtask

    task automatic next(input logic [7:0] d0, input logic [7:0] d1);
        tx[0] = 8'hAD; tx[1] = d0; tx[2] = d1;
        send(3);
    endtask

    task automatic t_reset();
        chk(!aai_mode && !wel && !busy && !wr_req && !so_oe, "R1 reset outputs",
            {aai_mode, wel, busy, wr_req, so_oe}, 0);
    endtask

    task automatic t_no_wel();
        nlog = 0; first(8'h20, 8'h11, 8'h22); settle();
        chk(nlog == 0 && !aai_mode, "R3 entry without wel ignored", nlog, 0);
    endtask

    task automatic t_latch();
        op1(8'h06); chk(wel == 1'b1, "R2 wren sets wel", wel, 1);
        op1(8'h04); chk(wel == 1'b0, "R2 wrdi clears wel", wel, 0);
    endtask

    task automatic t_first();
        op1(8'h06);
        nlog = 0; first(8'h21, 8'h11, 8'h22); settle();
        chk(nlog == 2, "R3 two writes", nlog, 2);
        chk(log_a[0] == 8'h20 && log_d[0] == 8'h11, "R3 low byte", {log_a[0], log_d[0]}, 16'h2011);
        chk(log_a[1] == 8'h21 && log_d[1] == 8'h22, "R3 high byte", {log_a[1], log_d[1]}, 16'h2122);
        chk(aai_mode && wel, "R3 mode and wel set", {aai_mode, wel}, 3);
        chk(blast == BC + 2, "R6 busy length", blast, BC + 2);
    endtask

    task automatic t_malformed();
        nlog = 0;
        tx[0] = 8'hAD; tx[1] = 8'h77; send(2); settle();
        first(8'h30, 8'h55, 8'h66); settle();
        send(0); settle();
        chk(nlog == 0 && aai_mode, "R5 malformed frames no write", nlog, 0);
    endtask

    task automatic t_next();
        nlog = 0; next(8'h33, 8'h44); settle();
        chk(nlog == 2 && log_a[0] == 8'h22 && log_d[0] == 8'h33, "R4 next low",
            {log_a[0], log_d[0]}, 16'h2233);
        chk(log_a[1] == 8'h23 && log_d[1] == 8'h44, "R4 next high", {log_a[1], log_d[1]}, 16'h2344);
    endtask

    task automatic t_busy_ignore();
        nlog = 0; next(8'h55, 8'h66); next(8'h77, 8'h88); settle();
        chk(nlog == 2, "R6 command during busy ignored", nlog, 2);
        nlog = 0; next(8'h99, 8'hAA);
        tx[0] = 8'h04; send(1); settle();
        chk(nlog == 2 && log_a[0] == 8'h26, "R6 address after ignored frame", log_a[0], 8'h26);
        chk(aai_mode && wel, "R8 wrdi during busy ignored", {aai_mode, wel}, 3);
    endtask

    task automatic t_status();
        op1(8'h70);
        chk(so_oe && so_val, "R7 ready shown", {so_oe, so_val}, 3);
        next(8'hBB, 8'hCC);
        chk(so_oe && !so_val, "R7 busy shown", {so_oe, so_val}, 2);
        settle();
        chk(so_oe && so_val, "R7 ready again", {so_oe, so_val}, 3);
        op1(8'h80);
        chk(!so_oe, "R7 disabled", so_oe, 0);
    endtask

    task automatic t_exit_wrdi();
        op1(8'h04);
        chk(!aai_mode && !wel, "R8 wrdi exit", {aai_mode, wel}, 0);
        nlog = 0; next(8'h01, 8'h02); settle();
        chk(nlog == 0, "R8 continuation after exit ignored", nlog, 0);
    endtask

    task automatic t_exit_rdsr();
        op1(8'h06); first(8'h40, 8'h01, 8'h02); settle();
        tx[0] = 8'h05; tx[1] = 8'h00; tx[2] = 8'h00; send(3); settle();
        chk(!aai_mode && !wel, "R8 rdsr exit", {aai_mode, wel}, 0);
    endtask

    task automatic t_top();
        op1(8'h06);
        nlog = 0; first(8'hFC, 8'h0A, 8'h0B); settle();
        chk(aai_mode, "R9 mode active below top", aai_mode, 1);
        next(8'h0C, 8'h0D); settle();
        chk(nlog == 4 && log_a[2] == 8'hFE && log_a[3] == 8'hFF, "R9 top word address",
            {log_a[2], log_a[3]}, 16'hFEFF);
        chk(!aai_mode && !wel, "R9 mode ends at top", {aai_mode, wel}, 0);
        op1(8'h06);
        nlog = 0; next(8'h0E, 8'h0F); settle();
        chk(nlog == 0 && !aai_mode, "R9 no wrap", nlog, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_wel();
        t_latch();
        t_first();
        t_malformed();
        t_next();
        t_busy_ignore();
        t_status();
        t_exit_wrdi();
        t_exit_rdsr();
        t_top();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end
endmodule